// File: doc/BRIEF.md
# Lane-Partitioned Three-Operand Adder with Logic Unit

This block is the post-multiply arithmetic stage of a wide datapath. Each cycle it picks three operands, X, Y and Z, from a product input, a registered C operand, its own accumulator P, a cascade input, or constants. It then either adds or subtracts them together with a selectable carry-in, or applies a bitwise two-operand function to X and Z. The result is written into the accumulator register. The accumulator drives the output, so the block can also sum a stream of values.

The adder can be split at runtime into one full-width lane, two half-width lanes or four quarter-width lanes. Carries and borrows never cross a lane boundary. Each lane reports its own carry (or borrow) flag on a fixed bit of a four-bit flag output. The C operand sits in its own register, which has its own clear and its own load enable, separate from the accumulator's. The product input is only meaningful when the adder runs as a single lane; in the split modes the block treats the product as zero.

Top module: `simd_post_adder`

## Requirements
- R1: `rst` high at a rising edge makes `p_o` and `carry_o` zero after that edge. `c_rst` high at an edge clears the C register, whatever `rst` and `c_ce` are doing.
- R2: When `p_ce` is low (and `rst` is low), `p_o` and `carry_o` keep their values. When `c_ce` and `c_rst` are both low, the C register keeps its value.
- R3: `mode_i[1:0]` selects X: 0 zero, 1 product, 2 P, 3 cascade. `mode_i[3:2]` selects Y: 0 zero, 1 all ones, 2 C register, 3 product. `mode_i[6:4]` selects Z: 0 zero, 1 cascade, 2 P, 3 C register, 4 P shifted right by one quarter width with zero fill, 5 cascade shifted the same way, 6 and 7 zero.
- R4: With `op_i` = 0, or any code from 9 to 15, each lane of P becomes (X+Y+Z+cin) modulo 2^lane width. The lane's flag is 1 exactly when that unsigned sum is at least 2^lane width.
- R5: With `op_i` = 1, each lane of P becomes Z-(X+Y+cin) modulo 2^lane width. The lane's flag is 1 exactly when X+Y+cin exceeds Z (unsigned, a borrow).
- R6: `lane_mode_i` selects the lane split: 0 one 48-bit lane, 1 two 24-bit lanes, 2 or 3 four 12-bit lanes. No carry or borrow passes between lanes. The flag of a lane is placed on the `carry_o` bit of its most significant quarter (one lane: bit 3; two lanes: bits 1 and 3; four lanes: bits 0 to 3). All other bits are 0.
- R7: `cin_sel_i` selects the carry-in: 0 zero, 1 `cin_i`, 2 one, 3 previous `carry_o[3]`, 4 P bit 47, 5 inverted P bit 47, 6 C register bit 47, 7 inverted C register bit 47. Only the lowest lane receives it; the other lanes start with 0.
- R8: When `lane_mode_i` is not 0, every product selection (X code 1, Y code 3) supplies zero.
- R9: `op_i` selects a bitwise function of X and Z: 2 AND, 3 OR, 4 XOR, 5 NAND, 6 NOR, 7 XNOR, 8 NOT X. In these modes `carry_o` becomes 0, and Y and the carry-in have no effect.
- R10: Results appear on `p_o` and `carry_o` one rising edge after the inputs are applied. A value loaded into C is seen by an operand select from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear of accumulator and flags |
| c_rst | input | 1 | Synchronous clear of the C register |
| c_ce | input | 1 | Load enable of the C register |
| p_ce | input | 1 | Update enable of accumulator and flags |
| prod_i | input | 48 | Product operand |
| c_i | input | 48 | Data for the C register |
| casc_i | input | 48 | Cascade operand |
| mode_i | input | 7 | Operand select word (X, Y, Z fields) |
| lane_mode_i | input | 2 | Lane split select |
| op_i | input | 4 | Arithmetic or logic function code |
| cin_sel_i | input | 3 | Carry-in source select |
| cin_i | input | 1 | External carry-in |
| p_o | output | 48 | Accumulator value |
| carry_o | output | 4 | Per-lane carry or borrow flags |

## Verification
The properties assume that every control input is at a defined value at each rising edge. Once the block leaves reset, their only reference point is the state registered one edge earlier. They do not assume that `rst` and `c_rst` are mutually exclusive, or that the lane mode stays the same from one cycle to the next. The stimulus changes inputs only on falling edges and always drives defined values. Reset and C clear are asserted only rarely, so that long runs of accumulation, lane switching and carry feedback through selector 3 occur between them.

// File: rtl/simd_pa_pkg.sv
package simd_pa_pkg;

    // number of quarter segments in the adder
    localparam int NSEG = 4;

    // function codes
    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_SUB  = 4'd1;
    localparam logic [3:0] OP_AND  = 4'd2;
    localparam logic [3:0] OP_OR   = 4'd3;
    localparam logic [3:0] OP_XOR  = 4'd4;
    localparam logic [3:0] OP_NAND = 4'd5;
    localparam logic [3:0] OP_NOR  = 4'd6;
    localparam logic [3:0] OP_XNOR = 4'd7;
    localparam logic [3:0] OP_NOTX = 4'd8;

    typedef enum logic [1:0] {
        SPLIT_ONE  = 2'd0,
        SPLIT_TWO  = 2'd1,
        SPLIT_FOUR = 2'd2,
        SPLIT_ALT4 = 2'd3
    } split_e;

    function automatic logic is_logic_op(input logic [3:0] op);
        return (op >= OP_AND) && (op <= OP_NOTX);
    endfunction

    function automatic logic is_quad(input logic [1:0] lm);
        return lm[1];
    endfunction

    function automatic logic is_dual(input logic [1:0] lm);
        return !lm[1] && lm[0];
    endfunction

endpackage

// File: rtl/sp_operand_mux.sv
module sp_operand_mux
    import simd_pa_pkg::*;
#(
    parameter int QW = 12
) (
    input  logic [6:0]         mode,
    input  logic [1:0]         lane_mode,
    input  logic [NSEG*QW-1:0] prod,
    input  logic [NSEG*QW-1:0] casc,
    input  logic [NSEG*QW-1:0] p_fb,
    input  logic [NSEG*QW-1:0] c_reg,
    output logic [NSEG*QW-1:0] x_op,
    output logic [NSEG*QW-1:0] y_op,
    output logic [NSEG*QW-1:0] z_op
);
    localparam int W = NSEG * QW;

    logic [W-1:0] prod_g;

    // product only valid as a single full-width lane
    always_comb begin
        prod_g = (lane_mode == SPLIT_ONE) ? prod : '0;
    end

    always_comb begin
        unique case (mode[1:0])
            2'd0:    x_op = '0;
            2'd1:    x_op = prod_g;
            2'd2:    x_op = p_fb;
            default: x_op = casc;
        endcase
    end

    always_comb begin
        unique case (mode[3:2])
            2'd0:    y_op = '0;
            2'd1:    y_op = '1;
            2'd2:    y_op = c_reg;
            default: y_op = prod_g;
        endcase
    end

    always_comb begin
        case (mode[6:4])
            3'd1:    z_op = casc;
            3'd2:    z_op = p_fb;
            3'd3:    z_op = c_reg;
            3'd4:    z_op = p_fb >> QW;
            3'd5:    z_op = casc >> QW;
            default: z_op = '0;
        endcase
    end

endmodule

// File: rtl/sp_seg_adder.sv
module sp_seg_adder
    import simd_pa_pkg::*;
#(
    parameter int QW = 12
) (
    input  logic [NSEG*QW-1:0] x_op,
    input  logic [NSEG*QW-1:0] y_op,
    input  logic [NSEG*QW-1:0] z_op,
    input  logic               sub,
    input  logic               cin,
    input  logic [1:0]         lane_mode,
    output logic [NSEG*QW-1:0] sum,
    output logic [NSEG-1:0]    flags
);
    localparam int W  = NSEG * QW;
    localparam int SW = QW + 3;

    logic [1:0] k_out [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic          starts, ends;
        logic [1:0]    k_in;
        logic [SW-1:0] xe, ye, ze, ke, t, val;
        logic [2:0]    hi, neg_hi;

        always_comb begin
            starts = (g == 0) || is_quad(lane_mode)
                     || (is_dual(lane_mode) && (g == NSEG / 2));
            ends   = (g == NSEG - 1) || is_quad(lane_mode)
                     || (is_dual(lane_mode) && (g == NSEG / 2 - 1));
        end

        if (g == 0) begin : g_first
            always_comb k_in = {1'b0, cin};
        end else begin : g_rest
            always_comb k_in = starts ? 2'b00 : k_out[g-1];
        end

        always_comb begin
            xe     = {3'b000, x_op[g*QW +: QW]};
            ye     = {3'b000, y_op[g*QW +: QW]};
            ze     = {3'b000, z_op[g*QW +: QW]};
            ke     = {{(SW-2){1'b0}}, k_in};
            t      = xe + ye + ke;
            val    = sub ? (ze - t) : (ze + t);
            hi     = val[SW-1:QW];
            neg_hi = 3'd0 - hi;
            k_out[g] = sub ? neg_hi[1:0] : hi[1:0];
            sum[g*QW +: QW] = val[QW-1:0];
            flags[g] = ends && (k_out[g] != 2'b00);
        end
    end

endmodule

// File: rtl/sp_logic_unit.sv
module sp_logic_unit
    import simd_pa_pkg::*;
#(
    parameter int W = 48
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] x_op,
    input  logic [W-1:0] z_op,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = x_op & z_op;
            OP_OR:   res = x_op | z_op;
            OP_XOR:  res = x_op ^ z_op;
            OP_NAND: res = ~(x_op & z_op);
            OP_NOR:  res = ~(x_op | z_op);
            OP_XNOR: res = ~(x_op ^ z_op);
            OP_NOTX: res = ~x_op;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/simd_post_adder.sv
module simd_post_adder
    import simd_pa_pkg::*;
#(
    parameter int QW = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               c_rst,
    input  logic               c_ce,
    input  logic               p_ce,
    input  logic [NSEG*QW-1:0] prod_i,
    input  logic [NSEG*QW-1:0] c_i,
    input  logic [NSEG*QW-1:0] casc_i,
    input  logic [6:0]         mode_i,
    input  logic [1:0]         lane_mode_i,
    input  logic [3:0]         op_i,
    input  logic [2:0]         cin_sel_i,
    input  logic               cin_i,
    output logic [NSEG*QW-1:0] p_o,
    output logic [NSEG-1:0]    carry_o
);
    localparam int W = NSEG * QW;

    typedef struct packed {
        logic [W-1:0]    p;
        logic [NSEG-1:0] cy;
        logic [W-1:0]    c;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]    x_op, y_op, z_op, add_sum, lu_res, c_reg_q;
    logic [NSEG-1:0] add_flags;
    logic            cin_sel_d;

    always_comb c_reg_q = state_q.c;

    always_comb begin
        case (cin_sel_i)
            3'd1:    cin_sel_d = cin_i;
            3'd2:    cin_sel_d = 1'b1;
            3'd3:    cin_sel_d = state_q.cy[NSEG-1];
            3'd4:    cin_sel_d = state_q.p[W-1];
            3'd5:    cin_sel_d = ~state_q.p[W-1];
            3'd6:    cin_sel_d = state_q.c[W-1];
            3'd7:    cin_sel_d = ~state_q.c[W-1];
            default: cin_sel_d = 1'b0;
        endcase
    end

    sp_operand_mux #(.QW(QW)) u_mux (
        .mode      (mode_i),
        .lane_mode (lane_mode_i),
        .prod      (prod_i),
        .casc      (casc_i),
        .p_fb      (state_q.p),
        .c_reg     (state_q.c),
        .x_op      (x_op),
        .y_op      (y_op),
        .z_op      (z_op)
    );

    sp_seg_adder #(.QW(QW)) u_add (
        .x_op      (x_op),
        .y_op      (y_op),
        .z_op      (z_op),
        .sub       (op_i == OP_SUB),
        .cin       (cin_sel_d),
        .lane_mode (lane_mode_i),
        .sum       (add_sum),
        .flags     (add_flags)
    );

    sp_logic_unit #(.W(W)) u_lu (
        .op   (op_i),
        .x_op (x_op),
        .z_op (z_op),
        .res  (lu_res)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.p  = '0;
            state_d.cy = '0;
        end else if (p_ce) begin
            if (is_logic_op(op_i)) begin
                state_d.p  = lu_res;
                state_d.cy = '0;
            end else begin
                state_d.p  = add_sum;
                state_d.cy = add_flags;
            end
        end
        if (c_rst) begin
            state_d.c = '0;
        end else if (c_ce) begin
            state_d.c = c_i;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        p_o     = state_q.p;
        carry_o = state_q.cy;
    end

endmodule

// File: rtl/simd_post_adder_chk.sv
module simd_post_adder_chk
    import simd_pa_pkg::*;
#(
    parameter int QW = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               c_rst,
    input logic               c_ce,
    input logic               p_ce,
    input logic [6:0]         mode_i,
    input logic [1:0]         lane_mode_i,
    input logic [3:0]         op_i,
    input logic [2:0]         cin_sel_i,
    input logic [NSEG*QW-1:0] p_o,
    input logic [NSEG-1:0]    carry_o,
    input logic [NSEG*QW-1:0] c_reg_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (p_o == '0) && (carry_o == '0)); // R1

    AST_C_CLEAR: assert property (@(posedge clk) disable iff (rst) c_rst |=> (c_reg_q == '0)); // R1

    AST_P_HOLD: assert property (@(posedge clk) disable iff (rst) !p_ce |=> $stable(p_o) && $stable(carry_o)); // R2

    AST_C_HOLD: assert property (@(posedge clk) disable iff (rst) (!c_ce && !c_rst) |=> $stable(c_reg_q)); // R2

    AST_ONE_LANE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (p_ce && lane_mode_i == 2'd0) |=> (carry_o[2:0] == 3'b000)); // R6

    AST_TWO_LANE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (p_ce && lane_mode_i == 2'd1) |=> (carry_o[0] == 1'b0) && (carry_o[2] == 1'b0)); // R6

    AST_PROD_GATED: assert property (@(posedge clk) disable iff (rst)
        (p_ce && lane_mode_i != 2'd0 && mode_i == 7'b0001101 && op_i == OP_ADD && cin_sel_i == 3'd0)
        |=> (p_o == '0)); // R8

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (p_ce && is_logic_op(op_i)) |=> (carry_o == '0)); // R9

    AST_AND_ZERO: assert property (@(posedge clk) disable iff (rst)
        (p_ce && op_i == OP_AND && mode_i[1:0] == 2'd0) |=> (p_o == '0)); // R9

endmodule

bind simd_post_adder simd_post_adder_chk #(.QW(QW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .c_rst       (c_rst),
    .c_ce        (c_ce),
    .p_ce        (p_ce),
    .mode_i      (mode_i),
    .lane_mode_i (lane_mode_i),
    .op_i        (op_i),
    .cin_sel_i   (cin_sel_i),
    .p_o         (p_o),
    .carry_o     (carry_o),
    .c_reg_q     (c_reg_q)
);

// File: tb/simd_post_adder_test.sv
module simd_post_adder_test;

    localparam int W = 48;

    logic          clk = 1'b0;
    logic          rst, c_rst, c_ce, p_ce, cin_i;
    logic [W-1:0]  prod_i, c_i, casc_i;
    logic [6:0]    mode_i;
    logic [1:0]    lane_mode_i;
    logic [3:0]    op_i;
    logic [2:0]    cin_sel_i;
    logic [W-1:0]  p_o;
    logic [3:0]    carry_o;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    logic [W-1:0] m_p  = '0;
    logic [3:0]   m_cy = '0;
    logic [W-1:0] m_c  = '0;

    always #2 clk = ~clk;

    simd_post_adder uut (
        .clk(clk), .rst(rst), .c_rst(c_rst), .c_ce(c_ce), .p_ce(p_ce),
        .prod_i(prod_i), .c_i(c_i), .casc_i(casc_i), .mode_i(mode_i),
        .lane_mode_i(lane_mode_i), .op_i(op_i), .cin_sel_i(cin_sel_i),
        .cin_i(cin_i), .p_o(p_o), .carry_o(carry_o)
    );

    function automatic logic [W-1:0] rnd48();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    // returns {flags, result}
    function automatic logic [W+3:0] model_calc(input logic [W-1:0] x, y, z,
                                                input logic cin, input logic [3:0] op,
                                                input logic [1:0] lm);
        logic [63:0] res = 64'd0;
        logic [3:0]  fl  = 4'd0;
        int nl, lw;
        longint mask, xs, ys, zs, k, s;
        if (op >= 4'd2 && op <= 4'd8) begin
            case (op)
                4'd2: res[W-1:0] = x & z;
                4'd3: res[W-1:0] = x | z;
                4'd4: res[W-1:0] = x ^ z;
                4'd5: res[W-1:0] = ~(x & z);
                4'd6: res[W-1:0] = ~(x | z);
                4'd7: res[W-1:0] = ~(x ^ z);
                default: res[W-1:0] = ~x;
            endcase
            return {4'd0, res[W-1:0]};
        end
        nl = lm[1] ? 4 : (lm[0] ? 2 : 1);
        lw = W / nl;
        mask = (64'sd1 <<< lw) - 1;
        for (int l = 0; l < nl; l++) begin
            xs = longint'({16'd0, x} >> (l * lw)) & mask;
            ys = longint'({16'd0, y} >> (l * lw)) & mask;
            zs = longint'({16'd0, z} >> (l * lw)) & mask;
            k  = (l == 0) ? longint'(cin) : 0;
            if (op == 4'd1) begin
                s = zs - (xs + ys + k);
                fl[(l + 1) * (4 / nl) - 1] = (s < 0);
            end else begin
                s = xs + ys + zs + k;
                fl[(l + 1) * (4 / nl) - 1] = (s > mask);
            end
            res = res | ((s & mask) << (l * lw));
        end
        return {fl, res[W-1:0]};
    endfunction

    task automatic step(input string tag);
        logic [W-1:0] x, y, z, pg, e_p, e_c;
        logic [3:0]   e_cy;
        logic         ci;
        logic [W+3:0] r;
        pg = (lane_mode_i == 2'd0) ? prod_i : '0;
        case (mode_i[1:0])
            2'd0: x = '0;  2'd1: x = pg;  2'd2: x = m_p;  default: x = casc_i;
        endcase
        case (mode_i[3:2])
            2'd0: y = '0;  2'd1: y = '1;  2'd2: y = m_c;  default: y = pg;
        endcase
        case (mode_i[6:4])
            3'd1: z = casc_i;
            3'd2: z = m_p;
            3'd3: z = m_c;
            3'd4: z = m_p >> 12;
            3'd5: z = casc_i >> 12;
            default: z = '0;
        endcase
        case (cin_sel_i)
            3'd0: ci = 1'b0;
            3'd1: ci = cin_i;
            3'd2: ci = 1'b1;
            3'd3: ci = m_cy[3];
            3'd4: ci = m_p[W-1];
            3'd5: ci = ~m_p[W-1];
            3'd6: ci = m_c[W-1];
            default: ci = ~m_c[W-1];
        endcase
        r = model_calc(x, y, z, ci, op_i, lane_mode_i);
        e_p = m_p; e_cy = m_cy; e_c = m_c;
        if (rst) begin
            e_p = '0; e_cy = '0;
        end else if (p_ce) begin
            e_p = r[W-1:0]; e_cy = r[W+3:W];
        end
        if (c_rst) e_c = '0;
        else if (c_ce) e_c = c_i;
        @(posedge clk);
        #1;
        n_checks++;
        if (p_o !== e_p || carry_o !== e_cy) begin
            n_fail++;
            $display("FAIL %s: p_o=%h carry_o=%b expected p=%h carry=%b",
                     tag, p_o, carry_o, e_p, e_cy);
        end
        m_p = e_p; m_cy = e_cy; m_c = e_c;
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; c_rst = 0; c_ce = 0; p_ce = 1; cin_i = 0;
        prod_i = '0; c_i = '0; casc_i = '0;
        mode_i = '0; lane_mode_i = 2'd0; op_i = 4'd0; cin_sel_i = 3'd0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        idle();
        rst = 1; c_rst = 1;
        @(negedge clk);
        step("R1");                                  // reset state
        step("R1");
        idle();

        // R10: load C, P held (R2) while loading
        c_ce = 1; c_i = 48'h8123_4567_89AB; p_ce = 0;
        step("R2");
        c_ce = 0; p_ce = 1; c_i = 48'h1111_1111_1111;
        mode_i = 7'b000_10_00;                      // Y = C
        step("R10");
        c_rst = 1; c_ce = 1;                        // clear wins over load
        step("R1");
        c_rst = 0; c_ce = 0;
        step("R1");                                  // Y = C now zero

        // R4 full lane wrap with carry out of bit 47
        casc_i = '1; mode_i = 7'b000_01_11;         // X = cascade, Y = ones
        step("R4");
        // R6/R7: four lanes, carry-in one, no propagation
        mode_i = 7'b001_00_00; cin_sel_i = 3'd2; lane_mode_i = 2'd2;
        step("R6");
        lane_mode_i = 2'd1;
        step("R6");
        lane_mode_i = 2'd3;
        step("R6");
        // R7 feedback of previous top flag
        lane_mode_i = 2'd0; cin_sel_i = 3'd3; casc_i = '0; mode_i = 7'b010_00_00;
        step("R7");
        // R5 borrow
        op_i = 4'd1; casc_i = 48'd5; mode_i = 7'b000_00_11; cin_sel_i = 3'd1; cin_i = 1;
        step("R5");
        casc_i = 48'h000_001_000_003; lane_mode_i = 2'd2; mode_i = 7'b101_00_11;
        step("R5");
        // R8 product gated in split modes
        op_i = 4'd0; prod_i = 48'hABCD_EF01_2345; mode_i = 7'b000_11_01; cin_sel_i = 3'd0;
        step("R8");
        lane_mode_i = 2'd0;
        step("R3");
        // R4 unused codes behave as add
        op_i = 4'd12; mode_i = 7'b010_00_01;
        step("R4");
        // R9 logic functions, Y and carry-in without effect
        casc_i = 48'hF0F0_1234_00FF;
        for (int o = 2; o <= 8; o++) begin
            op_i = 4'(o); mode_i = 7'b010_01_11; cin_sel_i = 3'd2;
            step("R9");
        end
        // R2 hold
        p_ce = 0; op_i = 4'd0; mode_i = 7'b001_01_11;
        step("R2");
        step("R2");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            string tag;
            r = $urandom();
            rst   = (r[5:0] == 6'd0);
            c_rst = (r[11:6] == 6'd0);
            c_ce  = r[12];
            p_ce  = (r[15:13] != 3'd0);
            cin_i = r[16];
            lane_mode_i = r[18:17];
            cin_sel_i   = r[21:19];
            mode_i      = 7'($urandom());
            op_i        = (r[25:22] == 4'd0) ? 4'(9 + r[28:26]) : 4'($urandom_range(0, 8));
            prod_i = rnd48(); c_i = rnd48(); casc_i = rnd48();
            if (r[31:29] == 3'd0) casc_i = '1;
            if (op_i == 4'd1)                     tag = "R5";
            else if (op_i >= 4'd2 && op_i <= 4'd8) tag = "R9";
            else                                  tag = "R4";
            step(tag);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule